// File: doc/BRIEF.md
# EDO Dynamic Memory Device Model

This block is a synthesizable, clock-sampled model of the device side of an extended-data-out dynamic memory with a 16-bit word and a multiplexed address. A memory controller under test connects to it as it would to a real part. The controller drives the row strobe, two byte-lane column strobes, a write enable, an output enable and an 8-bit address. The model answers on a split data bus with one output enable per byte lane. All strobes are sampled on a fast system clock, and their edges are found by comparing each sample with the one before it. Analog timing, electrical behaviour and charge decay are not modelled.

The row is captured from the address pins when the row strobe falls. The column is captured from the low `COL_W` address bits on each fall of a column strobe. Together they select a word in an array of 2^(ROW_W+COL_W) words. Setting `COL_W = 8` gives the full 64K-word organisation. The default of 3 keeps elaboration small.

Each row opening and each internal refresh is reported on a one-cycle refresh port, so a bench can count refreshes per row. The refresh row is taken from the address pins for a normal opening, and from an 8-bit internal counter when a column strobe was already low as the row strobe fell.

Top module: `edo_dram_model`

## Requirements
- R1: A row strobe fall with both column strobes high latches `addr[ROW_W-1:0]` as the row. A later column strobe fall latches `addr[COL_W-1:0]` as the column. The higher address bits are ignored at a column fall.
- R2: Out of reset, and in the cycle after the row strobe and both column strobes are sampled high, `dq_oe` is `2'b00`.
- R3: `dq_oe[0]` and `dq_i/dq_o[7:0]` belong to `lcas_n`, and `dq_oe[1]` and bits `[15:8]` belong to `ucas_n`. A lane whose strobe is high at a column fall is neither written nor driven.
- R4: `we_n` low at a column fall writes `dq_i` into the selected lanes, whatever `oe_n` is. The data bus is not driven in the following cycle.
- R5: `we_n` high and `oe_n` low at a column fall is a read. One clock later `dq_oe` equals the lanes whose strobe was low, and `dq_o` carries the stored word on those lanes.
- R6: While the row strobe stays low, every further column strobe fall accesses a new column of the same row. Reads and writes may be mixed freely.
- R7: Read data and lane enables stay driven after the column strobe rises. They are released one clock after the first of these: a new column fall, `oe_n` high, `we_n` low, or all strobes high.
- R8: A row strobe fall while a column strobe was already low (in the previous sample) is an internal refresh. It reports `rfsh_cbr = 1`, ignores the address pins, and does not write or drive the array.
- R9: The internal refresh row counter is 8 bits wide and is 0 after reset. It gives its value as `rfsh_row` and then increments, wrapping from 255 to 0.
- R10: One clock after each row strobe fall, `rfsh_valid` is high for exactly one cycle. For an external row, `rfsh_row` holds that row and `rfsh_cbr` is 0.
- R11: A column strobe held low while the row strobe rises and falls again performs an internal refresh. The read data stays driven on its lanes throughout.
- R12: A column strobe that falls in the same sample as the row strobe is not an access. The row opens normally and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DATA_W | Data from the controller |
| dq_o | output | DATA_W | Data to the controller |
| dq_oe | output | 2 | Per-lane output enable (bit 0 lower, bit 1 upper) |
| rfsh_valid | output | 1 | One-cycle pulse per row opening or internal refresh |
| rfsh_row | output | ROW_W | Row refreshed |
| rfsh_cbr | output | 1 | Refresh came from the internal counter |

## Verification
The bench goes after four corner cases:

- **Hold window after the column strobe rises.** A model that releases the bus on the rising edge would lose the extended output and fail the hold checks. A model that ignores `oe_n` or `we_n` would keep driving when it must let go.
- **Hidden refresh.** The column strobe stays low across a second row strobe fall. A decoder that takes this for a new access, or drops the held data, is caught.
- **Refresh counter across the 255-to-0 wrap.** The bench asserts `we_n` with random data during the internal refreshes, then reads the array back. A model that uses the external address or writes during refresh is caught.
- **Byte lanes and address bits.** Single-lane writes and reads, and column addresses with random upper bits, expose lane mixing or an over-wide column decode.

// File: rtl/edo_pkg.sv
// Shared types for the EDO memory model.
package edo_pkg;

    // Kind of access found at a column strobe fall during an open row.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,   // no column fall this sample
        ACC_READ  = 2'd1,   // write enable high, output enable low
        ACC_WRITE = 2'd2,   // write enable low (early write)
        ACC_BLIND = 2'd3    // column fall with neither read nor write
    } acc_kind_e;

endpackage

// File: rtl/edo_strobe_decode.sv
// Strobe decoder: finds row and column strobe edges by comparing each
// sample with the previous one, tracks the open row, and classifies
// each column fall.
// Assumes all strobes are synchronous to clk and that a column strobe
// falls at least one sample after the row strobe to access.
module edo_strobe_decode
    import edo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 3,
    parameter int LANES  = 2,
    localparam int AW    = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         acc_kind,
    output logic [LANES-1:0]  acc_lanes,
    output logic [AW-1:0]     acc_word,
    output logic              row_open,
    output logic              cbr_open,
    output logic [ROW_W-1:0]  ext_row,
    output logic              all_idle
);

    logic             ras_q;
    logic [LANES-1:0] cas_q;
    logic             row_active;
    logic [ROW_W-1:0] row_q;
    logic             ras_fall;
    logic             cas_held;
    logic             strobe_hit;

    assign ras_fall   = ras_q & ~ras_n;
    assign cas_held   = ~(&cas_q);
    assign row_open   = ras_fall & ~cas_held;
    assign cbr_open   = ras_fall & cas_held;
    assign ext_row    = addr[ROW_W-1:0];
    assign strobe_hit = (|(cas_q & ~cas_n)) & ~ras_n & row_active;
    assign acc_lanes  = ~cas_n;
    assign acc_word   = {row_q, addr[COL_W-1:0]};
    assign all_idle   = ras_n & (&cas_n);

    // Classify the current sample's column fall.
    always_comb begin
        if (!strobe_hit)  acc_kind = ACC_NONE;
        else if (!we_n)   acc_kind = ACC_WRITE;
        else if (!oe_n)   acc_kind = ACC_READ;
        else              acc_kind = ACC_BLIND;
    end

    // Keep previous strobe samples and the open-row state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q      <= 1'b1;
            cas_q      <= '1;
            row_active <= 1'b0;
            row_q      <= '0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (row_open) begin
                row_active <= 1'b1;
                row_q      <= ext_row;
            end else if (ras_n) begin
                row_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edo_refresh_ctr.sv
// Refresh reporter: emits a one-cycle record for every row opening.
// For internal refreshes the row comes from a wrapping counter that
// steps after use.
// Assumes row_open and cbr_open are never high together.
module edo_refresh_ctr #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_open,
    input  logic             cbr_open,
    input  logic [ROW_W-1:0] ext_row,
    output logic             rfsh_valid,
    output logic [ROW_W-1:0] rfsh_row,
    output logic             rfsh_cbr
);

    logic [ROW_W-1:0] ctr_q;

    // Register the refresh record and advance the internal counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q      <= '0;
            rfsh_valid <= 1'b0;
            rfsh_row   <= '0;
            rfsh_cbr   <= 1'b0;
        end else begin
            rfsh_valid <= row_open | cbr_open;
            if (cbr_open) begin
                rfsh_row <= ctr_q;
                rfsh_cbr <= 1'b1;
                ctr_q    <= ctr_q + 1'b1;
            end else if (row_open) begin
                rfsh_row <= ext_row;
                rfsh_cbr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edo_lane_array.sv
// Storage array: one word array per byte lane, so each lane writes
// independently. Reads are combinational from the shared address.
// Contents are not reset, as in a real dynamic array.
module edo_lane_array #(
    parameter int AW     = 11,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DEPTH = 1 << AW,
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_en,
    input  logic [AW-1:0]    word,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Write this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_en[g]) cells[word] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[word];
    end

endmodule

// File: rtl/edo_out_latch.sv
// Extended-output latch: captures read data at a column fall and keeps
// the lanes driven until a release condition is seen.
// Assumes acc_kind and acc_lanes come from the same sample.
module edo_out_latch
    import edo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         acc_kind,
    input  logic [LANES-1:0]  acc_lanes,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              all_idle,
    output logic [DATA_W-1:0] dq_o,
    output logic [LANES-1:0]  dq_oe
);

    logic [DATA_W-1:0] word_q;
    logic [LANES-1:0]  drv_q;

    // Load on a read, clear on any other fall or a release condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            drv_q  <= '0;
        end else begin
            case (acc_kind)
                ACC_READ: begin
                    drv_q  <= acc_lanes;
                    word_q <= rd_word;
                end
                ACC_WRITE, ACC_BLIND: drv_q <= '0;
                default: if (oe_n || !we_n || all_idle) drv_q <= '0;
            endcase
        end
    end

    assign dq_o  = word_q;
    assign dq_oe = drv_q;

endmodule

// File: rtl/edo_dram_model.sv
// Top of the EDO memory model: joins the strobe decoder, the refresh
// reporter, the per-lane array and the extended-output latch.
// Assumes the strobes are synchronous to clk. The bus is split into
// in, out and per-lane enable.
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [1:0]        dq_oe,
    output logic              rfsh_valid,
    output logic [ROW_W-1:0]  rfsh_row,
    output logic              rfsh_cbr
);

    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;
    localparam int AW     = ROW_W + COL_W;

    acc_kind_e         acc_kind;
    logic [LANES-1:0]  acc_lanes;
    logic [AW-1:0]     acc_word;
    logic              row_open;
    logic              cbr_open;
    logic [ROW_W-1:0]  ext_row;
    logic              all_idle;
    logic [LANES-1:0]  wr_en;
    logic [DATA_W-1:0] rd_word;

    edo_strobe_decode #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES)
    ) decode_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n),
        .cas_n({ucas_n, lcas_n}), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .acc_kind(acc_kind), .acc_lanes(acc_lanes), .acc_word(acc_word),
        .row_open(row_open), .cbr_open(cbr_open), .ext_row(ext_row),
        .all_idle(all_idle)
    );

    edo_refresh_ctr #(.ROW_W(ROW_W)) refresh_i (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .cbr_open(cbr_open),
        .ext_row(ext_row), .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row),
        .rfsh_cbr(rfsh_cbr)
    );

    assign wr_en = (acc_kind == ACC_WRITE) ? acc_lanes : '0;

    edo_lane_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) array_i (
        .clk(clk), .wr_en(wr_en), .word(acc_word), .wr_data(dq_i),
        .rd_data(rd_word)
    );

    edo_out_latch #(.DATA_W(DATA_W), .LANES(LANES)) out_i (
        .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_lanes(acc_lanes),
        .rd_word(rd_word), .oe_n(oe_n), .we_n(we_n), .all_idle(all_idle),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/edo_dram_model_chk.sv
// Property checker for the EDO memory model, attached by bind.
// Watches only the ports plus its own record of the last internal
// refresh row.
module edo_dram_model_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             lcas_n,
    input logic             ucas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [1:0]       dq_oe,
    input logic             rfsh_valid,
    input logic [ROW_W-1:0] rfsh_row,
    input logic             rfsh_cbr
);

    logic [ROW_W-1:0] last_cbr;
    logic [ROW_W-1:0] next_cbr;
    logic             seen_cbr;

    // Remember the row of the latest internal refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cbr <= '0;
            seen_cbr <= 1'b0;
        end else if (rfsh_valid && rfsh_cbr) begin
            last_cbr <= rfsh_row;
            seen_cbr <= 1'b1;
        end
    end

    assign next_cbr = last_cbr + 1'b1;

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && lcas_n && ucas_n) |=> (dq_oe == 2'b00)); // R2
    AST_LOWER_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> !$past(lcas_n)); // R3
    AST_UPPER_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[1]) |-> !$past(ucas_n)); // R3
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (dq_oe == 2'b00)); // R4
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00)); // R7
    AST_CBR_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_valid && rfsh_cbr && seen_cbr) |-> (rfsh_row == next_cbr)); // R9
    AST_RFSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_valid |=> !rfsh_valid); // R10

endmodule

bind edo_dram_model edo_dram_model_chk #(.ROW_W(ROW_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe),
    .rfsh_valid(rfsh_valid), .rfsh_row(rfsh_row), .rfsh_cbr(rfsh_cbr)
);

// File: tb/edo_dram_model_tb_top.sv
// Bench for the EDO memory model. It fills the array, runs directed
// corner cases, then runs random page sessions against a word model.
module edo_dram_model_tb_top;

    localparam int ROW_W = 8;
    localparam int COL_W = 3;
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1;
    logic        we_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic        rfsh_valid, rfsh_cbr;
    logic [7:0]  rfsh_row;

    int          vectors = 0;
    int          misses = 0;
    logic [15:0] model [DEPTH];
    logic [7:0]  exp_ctr = '0;
    logic [7:0]  cur_row = '0;

    always #10 clk = ~clk;

    edo_dram_model dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
        .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .rfsh_valid(rfsh_valid),
        .rfsh_row(rfsh_row), .rfsh_cbr(rfsh_cbr)
    );

    function automatic logic [15:0] pat(int r, int c);
        return 16'((r * 16'h0101) ^ (c * 16'h1357) ^ 16'hA5C3);
    endfunction

    function automatic logic [15:0] lane_mask(logic [1:0] l);
        return {{8{l[1]}}, {8{l[0]}}};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic open_row(logic [7:0] a);
        addr = a; ras_n = 1'b0;
        step();
        check("R10 rfsh_valid on open", rfsh_valid, 1);
        check("R10 rfsh_cbr on open", rfsh_cbr, 0);
        check("R1 row taken from address", rfsh_row, a);
        cur_row = a;
    endtask

    task automatic close_row();
        ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step();
        check("R2 standby bus released", dq_oe, 0);
    endtask

    task automatic access(string tag, logic [1:0] lanes, logic [7:0] a,
                          logic we, logic oe, logic [15:0] d);
        int idx = {cur_row, a[COL_W-1:0]};
        logic [15:0] m = lane_mask(lanes);
        addr = a; lcas_n = ~lanes[0]; ucas_n = ~lanes[1];
        we_n = we; oe_n = oe; dq_i = d;
        step();
        if (!we) begin
            model[idx] = (model[idx] & ~m) | (d & m);
            check({tag, " R4 write leaves bus undriven"}, dq_oe, 0);
        end else if (!oe) begin
            check({tag, " R3 read lane enables"}, dq_oe, lanes);
            check({tag, " R5 read data"}, dq_o & m, model[idx] & m);
        end else begin
            check({tag, " R7 read with OE high undriven"}, dq_oe, 0);
        end
        lcas_n = 1'b1; ucas_n = 1'b1;
        step();
        if (we && !oe) begin
            check({tag, " R7 lanes held after strobe rise"}, dq_oe, lanes);
            check({tag, " R7 data held after strobe rise"}, dq_o & m, model[idx] & m);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED0174));
        repeat (3) step();
        check("R2 reset bus released", dq_oe, 0);
        check("R10 reset no refresh", rfsh_valid, 0);
        rst_n = 1'b1;
        step();

        // Fill every word in page mode.
        for (int r = 0; r < (1 << ROW_W); r++) begin
            open_row(8'(r));
            for (int c = 0; c < (1 << COL_W); c++)
                access("R6", 2'b11, 8'(c), 1'b0, 1'b1, pat(r, c));
            close_row();
        end

        // Strobes falling together: row opens, nothing is written.
        addr = 8'h05; ras_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0;
        we_n = 1'b0; dq_i = 16'hDEAD;
        step();
        check("R12 row opened on joint fall", rfsh_row, 8'h05);
        check("R12 joint fall not refresh", rfsh_cbr, 0);
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1;
        step();
        close_row();
        open_row(8'h05);
        addr = 8'h05; lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0;
        step();
        check("R12 joint fall did not write", dq_o, pat(5, 5));
        close_row();

        // Page mode with byte lanes mixed.
        open_row(8'd9);
        access("R6", 2'b11, 8'd1, 1'b0, 1'b1, 16'h1111);
        access("R6", 2'b11, 8'd1, 1'b1, 1'b0, 16'h0);
        access("R3", 2'b01, 8'd2, 1'b0, 1'b1, 16'h77AB);
        access("R3", 2'b11, 8'd2, 1'b1, 1'b0, 16'h0);
        access("R3", 2'b10, 8'd2, 1'b1, 1'b0, 16'h0);
        access("R3", 2'b10, 8'd3, 1'b0, 1'b0, 16'hC400);
        access("R3", 2'b11, 8'd3, 1'b1, 1'b0, 16'h0);
        close_row();

        // Release of held data by OE high, then by WE low.
        open_row(8'd20);
        access("R7", 2'b11, 8'd3, 1'b1, 1'b0, 16'h0);
        oe_n = 1'b1;
        step();
        check("R7 OE high ends hold", dq_oe, 0);
        access("R7", 2'b11, 8'd4, 1'b1, 1'b0, 16'h0);
        we_n = 1'b0;
        step();
        check("R7 WE low ends hold", dq_oe, 0);
        close_row();

        // Hidden refresh during a lower-lane read.
        open_row(8'd30);
        addr = 8'd6; lcas_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        step();
        check("R11 lower read lanes", dq_oe, 2'b01);
        ras_n = 1'b1;
        step();
        check("R11 held across row strobe high", dq_oe, 2'b01);
        ras_n = 1'b0; addr = 8'hFF;
        step();
        check("R11 hidden refresh flagged", rfsh_cbr, 1);
        check("R9 hidden refresh row", rfsh_row, exp_ctr);
        exp_ctr++;
        check("R11 lanes held through refresh", dq_oe, 2'b01);
        check("R11 data held through refresh", dq_o[7:0], model[{8'd30, 3'd6}][7:0]);
        ras_n = 1'b1; lcas_n = 1'b1;
        step();
        check("R2 all strobes high releases", dq_oe, 0);
        oe_n = 1'b1;

        // Internal refresh loop across the counter wrap, WE held low.
        for (int i = 0; i < 260; i++) begin
            if (i % 2 == 0) lcas_n = 1'b0; else ucas_n = 1'b0;
            we_n = 1'b0; dq_i = 16'($urandom);
            step();
            ras_n = 1'b0; addr = 8'($urandom);
            step();
            check("R8 refresh flagged", rfsh_cbr, 1);
            check("R9 counter row", rfsh_row, exp_ctr);
            check("R8 refresh does not drive", dq_oe, 0);
            exp_ctr++;
            ras_n = 1'b1;
            step();
            lcas_n = 1'b1; ucas_n = 1'b1;
            step();
        end
        we_n = 1'b1;
        open_row(8'($urandom));
        for (int c = 0; c < (1 << COL_W); c++)
            access("R8", 2'b11, 8'(c), 1'b1, 1'b0, 16'h0);
        close_row();

        // Random page sessions; upper column address bits are random.
        for (int s = 0; s < 150; s++) begin
            open_row(8'($urandom));
            for (int k = 0; k < 1 + int'($urandom % 5); k++) begin
                access("R1", 2'(1 + $urandom % 3), 8'($urandom),
                       ($urandom % 3) != 0, ($urandom % 8) == 0,
                       16'($urandom));
            end
            close_row();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule